// File: doc/BRIEF.md
# Paged register window bridge

This block lets a host reach a wide internal register space through a small 32-bit configuration aperture. The host first stores a page number in a page-select register. It then reads or writes a fixed window, and the low bits of the window address pick a register inside the selected page. Each window access becomes one access on a simple internal register bus, at the address formed by joining the stored page number with the in-window offset. Read data from that bus comes back to the host.

Any internal access therefore takes two host operations: a page write, then a window access. The page value stays in place between accesses, so several window accesses may share one page write. Offsets that match neither the page register nor the window read as zero and have no effect when written.

Top module: `pgwin_bridge`

## Requirements
- R1: After synchronous reset the page register holds 0, `ib_rd`, `ib_wr` and `h_rvalid` are low, and a read of the page register returns 0.
- R2: A host write to offset 0x41C stores `h_wdata[22:0]` as the page number. A read of 0x41C returns that value with bits 31:23 zero.
- R3: A host write at window offset W (0x800 to 0x9FF) raises `ib_wr` for exactly one cycle, in the cycle after the request. In that cycle `ib_addr` = (page << 9) | (W − 0x800), `ib_wdata` equals the host data, and all `ib_be` bits are set.
- R4: A host read at window offset W raises `ib_rd` for one cycle, in the cycle after the request, with the same address mapping as R3. The target presents `ib_rdata` in the cycle after `ib_rd`. That value reaches `h_rdata` together with `h_rvalid` after the third rising edge following the request.
- R5: Host offsets outside 0x41C and the window produce no internal strobe, leave the page register unchanged when written, and read as 0.
- R6: Offset bits 1:0 are ignored. Internal addresses always have bits 1:0 at zero, and 0x41D to 0x41F select the page register.
- R7: The page number persists across any number of window accesses until the next page write.
- R8: Window bounds are inclusive at 0x800 and at the last word 0x9FC. Offsets 0x7FC and 0xA00 are outside the window.
- R9: One request may be accepted every cycle. `ib_rd` and `ib_wr` are never high together, and back-to-back reads return in request order, each with its own data.
- R10: Every host read, whatever its offset, yields exactly one `h_rvalid` pulse three edges later. Writes yield none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host request present this cycle |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | 12 | Host byte offset within the aperture |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Read data valid pulse |
| h_rdata | output | 32 | Read data returned to host |
| ib_rd | output | 1 | Internal bus read strobe |
| ib_wr | output | 1 | Internal bus write strobe |
| ib_addr | output | 32 | Internal bus address |
| ib_wdata | output | 32 | Internal bus write data |
| ib_be | output | 4 | Internal bus byte enables |
| ib_rdata | input | 32 | Internal bus read data, valid the cycle after `ib_rd` |

## Verification
Internal strobes, address and write data are due in the first cycle after a request is accepted. Read returns of every kind are due after the third edge. A page write affects a window access accepted in the next cycle. The bench predicts each result and files it under the cycle in which it falls due. At the falling edge of every cycle it compares all outputs with that cycle's prediction. A slot with no prediction means the strobes and `h_rvalid` must be low. The bench's target model answers each `ib_rd` only in the following cycle and drives junk at all other times. A bridge that samples `ib_rdata` in the wrong cycle therefore returns the wrong value.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;

  // Classification of a host offset
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PAGE = 2'd1,
    ACC_WIN  = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/pgwin_decode.sv
// Classifies a host word address and derives the in-window word offset.
module pgwin_decode
  import pgwin_pkg::*;
#(
  parameter int HOST_AW      = 12,
  parameter int OFS_W        = 9,
  parameter int PAGE_REG_OFS = 'h41C,
  parameter int WIN_BASE     = 'h800
) (
  input  logic [HOST_AW-3:0] word_addr,
  output acc_kind_e          kind,
  output logic [OFS_W-3:0]   win_wofs
);
  localparam int WA_W      = HOST_AW - 2;
  localparam int WOW       = OFS_W - 2;
  localparam int WIN_WORDS = 2 ** WOW;
  localparam logic [WA_W-1:0] PAGE_WA = WA_W'(PAGE_REG_OFS >> 2);
  localparam logic [WA_W-1:0] WIN_WA  = WA_W'(WIN_BASE >> 2);
  localparam logic [WA_W:0]   WIN_END = {1'b0, WIN_WA} + (WA_W+1)'(WIN_WORDS);

  logic hit_page;
  logic hit_win;

  always_comb begin
    hit_page = (word_addr == PAGE_WA);
    hit_win  = (word_addr >= WIN_WA) && ({1'b0, word_addr} < WIN_END);
    win_wofs = word_addr[WOW-1:0] - WIN_WA[WOW-1:0];
    if (hit_win)       kind = ACC_WIN;
    else if (hit_page) kind = ACC_PAGE;
    else               kind = ACC_NONE;
  end

endmodule

// File: rtl/pgwin_page_reg.sv
// Stored page number, reset to zero.
module pgwin_page_reg #(
  parameter int PAGE_W = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_val,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (rst)        page <= '0;
    else if (wr_en) page <= wr_val;
  end
endmodule

// File: rtl/pgwin_issue.sv
// First pipeline stage: registered internal bus request plus read bookkeeping.
module pgwin_issue
  import pgwin_pkg::*;
#(
  parameter int DW     = 32,
  parameter int PAGE_W = 23,
  parameter int OFS_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_v,
  input  logic                    req_wr,
  input  acc_kind_e               kind,
  input  logic [OFS_W-3:0]        wofs,
  input  logic [PAGE_W-1:0]       page,
  input  logic [DW-1:0]           wdata,
  input  logic [DW-1:0]           local_rd,
  output logic                    ib_rd,
  output logic                    ib_wr,
  output logic [PAGE_W+OFS_W-1:0] ib_addr,
  output logic [DW-1:0]           ib_wdata,
  output logic [DW/8-1:0]         ib_be,
  output logic                    s1_rd,
  output logic                    s1_win,
  output logic [DW-1:0]           s1_data
);
  localparam int BE_W = DW / 8;

  logic is_win;
  logic win_wr;
  logic win_rd;

  always_comb begin
    is_win = (kind == ACC_WIN);
    win_wr = req_v && req_wr && is_win;
    win_rd = req_v && !req_wr && is_win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ib_rd    <= 1'b0;
      ib_wr    <= 1'b0;
      ib_addr  <= '0;
      ib_wdata <= '0;
      ib_be    <= '0;
      s1_rd    <= 1'b0;
      s1_win   <= 1'b0;
      s1_data  <= '0;
    end else begin
      ib_rd  <= win_rd;
      ib_wr  <= win_wr;
      ib_be  <= {BE_W{win_wr}};
      if (win_rd || win_wr) ib_addr <= {page, wofs, 2'b00};
      if (win_wr)           ib_wdata <= wdata;
      s1_rd  <= req_v && !req_wr;
      s1_win <= is_win;
      if (req_v && !req_wr) s1_data <= local_rd;
    end
  end

endmodule

// File: rtl/pgwin_return.sv
// Second and third stages: wait for target data, then register the host reply.
module pgwin_return #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s1_rd,
  input  logic          s1_win,
  input  logic [DW-1:0] s1_data,
  input  logic [DW-1:0] ib_rdata,
  output logic          h_rvalid,
  output logic [DW-1:0] h_rdata
);
  logic          s2_rd;
  logic          s2_win;
  logic [DW-1:0] s2_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_rd    <= 1'b0;
      s2_win   <= 1'b0;
      s2_data  <= '0;
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
    end else begin
      s2_rd    <= s1_rd;
      s2_win   <= s1_win;
      if (s1_rd) s2_data <= s1_data;
      h_rvalid <= s2_rd;
      if (s2_rd) h_rdata <= s2_win ? ib_rdata : s2_data;
    end
  end

endmodule

// File: rtl/pgwin_bridge.sv
// Paged register window bridge, top level.
module pgwin_bridge
  import pgwin_pkg::*;
#(
  parameter int HOST_AW      = 12,
  parameter int DW           = 32,
  parameter int PAGE_W       = 23,
  parameter int OFS_W        = 9,
  parameter int PAGE_REG_OFS = 'h41C,
  parameter int WIN_BASE     = 'h800
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    h_valid,
  input  logic                    h_wr,
  input  logic [HOST_AW-1:0]      h_addr,
  input  logic [DW-1:0]           h_wdata,
  output logic                    h_rvalid,
  output logic [DW-1:0]           h_rdata,
  output logic                    ib_rd,
  output logic                    ib_wr,
  output logic [PAGE_W+OFS_W-1:0] ib_addr,
  output logic [DW-1:0]           ib_wdata,
  output logic [DW/8-1:0]         ib_be,
  input  logic [DW-1:0]           ib_rdata
);
  localparam int WOW = OFS_W - 2;

  acc_kind_e         kind;
  logic [WOW-1:0]    wofs;
  logic [PAGE_W-1:0] page;
  logic [DW-1:0]     local_rd;
  logic              page_we;
  logic              s1_rd;
  logic              s1_win;
  logic [DW-1:0]     s1_data;
  logic              addr_lo_unused;

  assign addr_lo_unused = ^h_addr[1:0];

  pgwin_decode #(
    .HOST_AW(HOST_AW), .OFS_W(OFS_W),
    .PAGE_REG_OFS(PAGE_REG_OFS), .WIN_BASE(WIN_BASE)
  ) u_decode (
    .word_addr(h_addr[HOST_AW-1:2]),
    .kind     (kind),
    .win_wofs (wofs)
  );

  always_comb begin
    page_we  = h_valid && h_wr && (kind == ACC_PAGE);
    local_rd = (kind == ACC_PAGE) ? DW'(page) : '0;
  end

  pgwin_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk   (clk),
    .rst   (rst),
    .wr_en (page_we),
    .wr_val(h_wdata[PAGE_W-1:0]),
    .page  (page)
  );

  pgwin_issue #(.DW(DW), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_issue (
    .clk     (clk),
    .rst     (rst),
    .req_v   (h_valid),
    .req_wr  (h_wr),
    .kind    (kind),
    .wofs    (wofs),
    .page    (page),
    .wdata   (h_wdata),
    .local_rd(local_rd),
    .ib_rd   (ib_rd),
    .ib_wr   (ib_wr),
    .ib_addr (ib_addr),
    .ib_wdata(ib_wdata),
    .ib_be   (ib_be),
    .s1_rd   (s1_rd),
    .s1_win  (s1_win),
    .s1_data (s1_data)
  );

  pgwin_return #(.DW(DW)) u_return (
    .clk     (clk),
    .rst     (rst),
    .s1_rd   (s1_rd),
    .s1_win  (s1_win),
    .s1_data (s1_data),
    .ib_rdata(ib_rdata),
    .h_rvalid(h_rvalid),
    .h_rdata (h_rdata)
  );

endmodule

// File: rtl/pgwin_bridge_chk.sv
// Protocol checker attached to the bridge.
module pgwin_bridge_chk #(
  parameter int HOST_AW      = 12,
  parameter int DW           = 32,
  parameter int PAGE_W       = 23,
  parameter int OFS_W        = 9,
  parameter int PAGE_REG_OFS = 'h41C,
  parameter int WIN_BASE     = 'h800
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    h_valid,
  input logic                    h_wr,
  input logic [HOST_AW-1:0]      h_addr,
  input logic [DW-1:0]           h_wdata,
  input logic                    h_rvalid,
  input logic                    ib_rd,
  input logic                    ib_wr,
  input logic [PAGE_W+OFS_W-1:0] ib_addr,
  input logic [DW-1:0]           ib_wdata,
  input logic [DW/8-1:0]         ib_be
);
  localparam int WIN_LAST = WIN_BASE + (2 ** OFS_W) - 1;

  logic in_win;
  logic in_page;
  logic outside;

  always_comb begin
    in_win  = (int'(h_addr) >= WIN_BASE) && (int'(h_addr) <= WIN_LAST);
    in_page = (h_addr[HOST_AW-1:2] == (HOST_AW-2)'(PAGE_REG_OFS >> 2));
    outside = !in_win && !in_page;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ib_rd && !ib_wr && !h_rvalid));

  assert_win_write_R3: assert property (@(posedge clk) disable iff (rst)
    (h_valid && h_wr && in_win) |=> (ib_wr && ib_wdata == $past(h_wdata) && (&ib_be)));

  assert_win_read_R4: assert property (@(posedge clk) disable iff (rst)
    (h_valid && !h_wr && in_win) |=> (ib_rd && !ib_wr));

  assert_no_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (h_valid && outside) |=> (!ib_rd && !ib_wr));

  assert_word_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (ib_rd || ib_wr) |-> (ib_addr[1:0] == 2'b00));

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !(ib_rd && ib_wr));

  assert_read_reply_R10: assert property (@(posedge clk) disable iff (rst)
    (h_valid && !h_wr) |-> ##3 h_rvalid);

  assert_reply_cause_R10: assert property (@(posedge clk) disable iff (rst)
    h_rvalid |-> $past(h_valid && !h_wr, 3));

endmodule

bind pgwin_bridge pgwin_bridge_chk #(
  .HOST_AW(HOST_AW), .DW(DW), .PAGE_W(PAGE_W), .OFS_W(OFS_W),
  .PAGE_REG_OFS(PAGE_REG_OFS), .WIN_BASE(WIN_BASE)
) i_chk (
  .clk(clk), .rst(rst), .h_valid(h_valid), .h_wr(h_wr), .h_addr(h_addr),
  .h_wdata(h_wdata), .h_rvalid(h_rvalid), .ib_rd(ib_rd), .ib_wr(ib_wr),
  .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_be(ib_be)
);

// File: tb/test_pgwin_bridge.sv
module test_pgwin_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_valid = 1'b0;
  logic        h_wr = 1'b0;
  logic [11:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic        h_rvalid;
  logic [31:0] h_rdata;
  logic        ib_rd;
  logic        ib_wr;
  logic [31:0] ib_addr;
  logic [31:0] ib_wdata;
  logic [3:0]  ib_be;
  logic [31:0] ib_rdata = 32'hBAD0_0000;

  always #10 clk = ~clk;

  pgwin_bridge i_pgwin_bridge (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .ib_rd(ib_rd), .ib_wr(ib_wr), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .ib_be(ib_be), .ib_rdata(ib_rdata)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  // prediction slots, indexed by cycle modulo 16
  bit          e_rd   [16];
  bit          e_wr   [16];
  logic [31:0] e_addr [16];
  logic [31:0] e_wd   [16];
  bit          e_rv   [16];
  logic [31:0] e_rdat [16];
  string       e_tag  [16];

  logic [22:0] m_page = '0;
  bit          t_pend = 0;
  logic [31:0] t_addr = '0;

  function automatic logic [31:0] hash(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic check_cycle();
    int i = cyc % 16;
    string t = (e_tag[i] == "") ? "R10" : e_tag[i];
    chk(t, "ib_rd", 32'(ib_rd), 32'(e_rd[i]));
    chk(t, "ib_wr", 32'(ib_wr), 32'(e_wr[i]));
    if (e_rd[i] || e_wr[i]) chk(t, "ib_addr", ib_addr, e_addr[i]);
    if (e_wr[i]) begin
      chk(t, "ib_wdata", ib_wdata, e_wd[i]);
      chk(t, "ib_be", 32'(ib_be), 32'hF);
    end
    chk(t, "h_rvalid", 32'(h_rvalid), 32'(e_rv[i]));
    if (e_rv[i]) chk(t, "h_rdata", h_rdata, e_rdat[i]);
    e_rd[i] = 0; e_wr[i] = 0; e_rv[i] = 0; e_tag[i] = "";
  endtask

  // One cycle: check outputs, run target model, drive request, predict results.
  task automatic step(bit v, bit w, logic [11:0] a, logic [31:0] d, string tag);
    int n1;
    int n3;
    bit is_win;
    bit is_pg;
    logic [31:0] ia;
    @(negedge clk);
    check_cycle();
    ib_rdata = t_pend ? hash(t_addr) : (32'hBAD0_0000 ^ 32'(cyc));
    t_pend = ib_rd;
    t_addr = ib_addr;
    h_valid = v; h_wr = w; h_addr = a; h_wdata = d;
    n1 = (cyc + 1) % 16;
    n3 = (cyc + 3) % 16;
    is_win = (a >= 12'h800) && (a <= 12'h9FF);
    is_pg  = (a[11:2] == 10'h107);
    ia = {m_page, a[8:2], 2'b00};
    if (v) begin
      e_tag[n1] = tag;
      if (is_win) begin
        e_addr[n1] = ia;
        if (w) begin e_wr[n1] = 1; e_wd[n1] = d; end
        else   e_rd[n1] = 1;
      end
      if (!w) begin
        e_rv[n3] = 1; e_tag[n3] = tag;
        e_rdat[n3] = is_win ? hash(ia) : (is_pg ? 32'(m_page) : 32'h0);
      end else if (is_pg) begin
        m_page = d[22:0];
      end
    end
    cyc++;
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(0, 0, 12'h0, 32'h0, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) e_tag[i] = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: quiet outputs and page reads zero after reset
    step(1, 0, 12'h41C, 32'h0, "R1");
    idle(4, "R1");
    // R2: page write keeps 23 bits, readback zero-extended
    step(1, 1, 12'h41C, 32'hFF81_2345, "R2");
    step(1, 0, 12'h41C, 32'h0, "R2");
    idle(3, "R2");
    // R3: window write mapping
    step(1, 1, 12'h810, 32'hCAFE_0001, "R3");
    idle(2, "R3");
    // R4: window read with target latency
    step(1, 0, 12'h844, 32'h0, "R4");
    idle(4, "R4");
    // R8: window bounds
    step(1, 0, 12'h800, 32'h0, "R8");
    step(1, 0, 12'h9FC, 32'h0, "R8");
    step(1, 0, 12'h7FC, 32'h0, "R8");
    step(1, 0, 12'hA00, 32'h0, "R8");
    step(1, 1, 12'hA00, 32'h1111_2222, "R8");
    step(1, 1, 12'h7FC, 32'h3333_4444, "R8");
    idle(4, "R8");
    // R5: unmapped writes leave page and bus untouched
    step(1, 1, 12'h420, 32'h0000_0777, "R5");
    step(1, 1, 12'h000, 32'h0000_0555, "R5");
    step(1, 0, 12'h41C, 32'h0, "R5");
    step(1, 0, 12'hFFC, 32'h0, "R5");
    idle(4, "R5");
    // R6: low offset bits ignored
    step(1, 1, 12'h41F, 32'h0000_7ABC, "R6");
    step(1, 0, 12'h41D, 32'h0, "R6");
    step(1, 0, 12'h813, 32'h0, "R6");
    step(1, 1, 12'h9FF, 32'h0BAD_F00D, "R6");
    idle(4, "R6");
    // R7: page kept over several window accesses
    step(1, 1, 12'h41C, 32'h0040_0001, "R7");
    step(1, 0, 12'h808, 32'h0, "R7");
    step(1, 1, 12'h90C, 32'h1234_5678, "R7");
    step(1, 0, 12'h9F0, 32'h0, "R7");
    idle(2, "R7");
    step(1, 0, 12'h41C, 32'h0, "R7");
    idle(4, "R7");
    // R9: back-to-back mixed traffic with page changes
    step(1, 0, 12'h800, 32'h0, "R9");
    step(1, 1, 12'h41C, 32'h0000_0003, "R9");
    step(1, 0, 12'h800, 32'h0, "R9");
    step(1, 0, 12'h41C, 32'h0, "R9");
    step(1, 0, 12'h804, 32'h0, "R9");
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom % 8;
      logic [11:0] a;
      if (sel == 0)      a = 12'h41C | 12'($urandom % 4);
      else if (sel < 6)  a = 12'h800 + 12'($urandom % 512);
      else               a = 12'($urandom % 4096);
      step(($urandom % 5) != 0, $urandom % 2, a, $urandom, "R9");
    end
    idle(5, "R10");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule